// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder

This block is a synthesizable, cycle-sampled stand-in for the control section of a by-four extended-data-out DRAM. It samples the active-low row strobe, column strobe, write enable and output enable on a fast clock. From their edges it works out which access the controller means: row open, column read or write, RAS-only refresh, CAS-before-RAS refresh, hidden refresh or self-refresh. It applies that access to a small internal array whose size is set by parameters.

The block is meant to sit opposite a DRAM controller under test. It gives that controller a memory that behaves like the real device at the strobe level. It reports each internal row refresh as a strobe with the row number. It raises an error pulse when a strobe's high time is shorter than a minimum given in clocks.

All outputs reflect the strobe values sampled at the most recent rising clock edge.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, `dq_oe`, `ref_stb`, `self_ref` and `timing_err` are all 0.
- R2: When `ras_n` falls while `cas_n` was high, the row on `addr` is opened and `ref_stb` pulses for one cycle with `ref_row` equal to that row. The data outputs stay undriven if `cas_n` never falls.
- R3: Write data is taken from `dq_in` at whichever comes later inside an open row: `cas_n` falling with `we_n` low, or `we_n` falling while `cas_n` is already low.
- R4: When `cas_n` falls in an open row with `we_n` high, the addressed word appears on `dq_out`. It stays driven while `cas_n` is high between page accesses, as long as `ras_n` and `oe_n` stay low and `we_n` stays high.
- R5: `dq_oe` is 0 whenever `ras_n` and `cas_n` have both been sampled high since the last read, and also whenever `oe_n` is high or `we_n` is low.
- R6: When `ras_n` falls while `cas_n` is already low, the block refreshes the row held in an internal counter and reports it on `ref_row`. The counter then advances by one and wraps from the last row to 0. The address, `we_n` and `oe_n` have no effect on the array.
- R7: If both strobes stay low for SELF_ENTER clocks after a CAS-before-RAS edge, `self_ref` rises. From then on, one counter row is refreshed every SELF_PERIOD clocks, whatever `cas_n` does. `self_ref` falls on the first clock that samples `ras_n` high.
- R8: In a hidden refresh, `cas_n` stays low after a read while `ras_n` goes high and then low again. That second fall is a counter refresh, and `dq_out` and `dq_oe` keep the read data throughout.
- R9: `timing_err` pulses for one cycle when `ras_n` falls after fewer than T_RP high samples. It also pulses when `cas_n` falls inside an open row after fewer than T_CP high samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Data output drive enable |
| ref_stb | output | 1 | One-cycle pulse per refreshed row |
| ref_row | output | ROW_BITS | Row refreshed with the current pulse |
| self_ref | output | 1 | Self-refresh active |
| timing_err | output | 1 | Strobe precharge minimum violated |

## Verification
The hardest situation to reach is self-refresh. It needs an unbroken CAS-before-RAS hold lasting SELF_ENTER clocks, and after that it must keep running while `cas_n` is released. The stimulus uses a small SELF_ENTER and opens a CBR cycle. It counts the clocks up to the entry edge, then raises `cas_n` part way through three refresh periods and checks that each refresh pulse comes in its expected cycle with the expected counter row. Hidden refresh is reached in a similar way: a read leaves `cas_n` low while `ras_n` is cycled, and the held data is checked before and after the second row-strobe fall.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_CBR  = 2'd2,
      ST_SELF = 2'd3
   } edo_state_e;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic oe_n,
   output logic r_ras,
   output logic r_cas,
   output logic r_we,
   output logic r_oe,
   output logic ras_fall,
   output logic cas_fall,
   output logic we_fall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_ras <= 1'b1;
         r_cas <= 1'b1;
         r_we  <= 1'b1;
         r_oe  <= 1'b1;
      end else begin
         r_ras <= ras_n;
         r_cas <= cas_n;
         r_we  <= we_n;
         r_oe  <= oe_n;
      end
   end

   // A falling edge is a high previous sample meeting a low present input.
   assign ras_fall = r_ras & ~ras_n;
   assign cas_fall = r_cas & ~cas_n;
   assign we_fall  = r_we  & ~we_n;
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
   import edo_pkg::*;
#(
   parameter int ROW_BITS    = 4,
   parameter int SELF_ENTER  = 12500,
   parameter int SELF_PERIOD = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                r_ras,
   input  logic                r_cas,
   input  logic                ras_fall,
   input  logic [ROW_BITS-1:0] addr_row,
   output edo_state_e          state,
   output logic                ref_stb,
   output logic [ROW_BITS-1:0] ref_row,
   output logic                self_ref
);
   localparam int TMAX = (SELF_ENTER > SELF_PERIOD) ? SELF_ENTER : SELF_PERIOD;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] ENTER_LAST  = TW'(SELF_ENTER - 1);
   localparam logic [TW-1:0] PERIOD_LAST = TW'(SELF_PERIOD - 1);

   logic [ROW_BITS-1:0] rcnt;
   logic [TW-1:0]       tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rcnt    <= '0;
         tmr     <= '0;
         ref_stb <= 1'b0;
         ref_row <= '0;
      end else begin
         ref_stb <= 1'b0;
         if (ras_fall) begin
            ref_stb <= 1'b1;
            tmr     <= '0;
            if (r_cas) begin
               state   <= ST_OPEN;
               ref_row <= addr_row;
            end else begin
               state   <= ST_CBR;
               ref_row <= rcnt;
               rcnt    <= rcnt + 1'b1;
            end
         end else if (ras_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
         end else begin
            unique case (state)
               ST_CBR: begin
                  if (cas_n) begin
                     tmr <= '0;
                  end else if (tmr == ENTER_LAST) begin
                     state <= ST_SELF;
                     tmr   <= '0;
                  end else begin
                     tmr <= tmr + 1'b1;
                  end
               end
               ST_SELF: begin
                  if (tmr == PERIOD_LAST) begin
                     tmr     <= '0;
                     ref_stb <= 1'b1;
                     ref_row <= rcnt;
                     rcnt    <= rcnt + 1'b1;
                  end else begin
                     tmr <= tmr + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign self_ref = (state == ST_SELF);

   assert_refresh_ras_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb |-> !r_ras);
   assert_self_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref |-> !r_ras);
   assert_self_from_cbr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(self_ref) |-> ($past(state) == ST_CBR));
endmodule

// File: rtl/edo_timing_mon.sv
module edo_timing_mon
   import edo_pkg::*;
#(
   parameter int T_RP = 3,
   parameter int T_CP = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       r_ras,
   input  logic       r_cas,
   input  logic       ras_fall,
   input  logic       cas_fall,
   input  edo_state_e state,
   output logic       timing_err
);
   localparam int RPW = $clog2(T_RP + 1);
   localparam int CPW = $clog2(T_CP + 1);
   localparam logic [RPW-1:0] RP_MIN = RPW'(T_RP);
   localparam logic [CPW-1:0] CP_MIN = CPW'(T_CP);

   logic [RPW-1:0] rp_cnt;
   logic [CPW-1:0] cp_cnt;

   // Saturating counts of consecutive high samples of each strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp_cnt     <= RP_MIN;
         cp_cnt     <= CP_MIN;
         timing_err <= 1'b0;
      end else begin
         if (!ras_n)                rp_cnt <= '0;
         else if (rp_cnt != RP_MIN) rp_cnt <= rp_cnt + 1'b1;
         if (!cas_n)                cp_cnt <= '0;
         else if (cp_cnt != CP_MIN) cp_cnt <= cp_cnt + 1'b1;
         timing_err <= (ras_fall && (rp_cnt < RP_MIN)) ||
                       (cas_fall && (state == ST_OPEN) && (cp_cnt < CP_MIN));
      end
   end

   assert_err_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err |-> (!r_ras || !r_cas));
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array
   import edo_pkg::*;
#(
   parameter int ROW_BITS = 4,
   parameter int COL_BITS = 4,
   parameter int DW       = 4,
   parameter bit EDO_MODE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                r_ras,
   input  logic                r_cas,
   input  logic                r_we,
   input  logic                r_oe,
   input  logic                ras_fall,
   input  logic                cas_fall,
   input  logic                we_fall,
   input  edo_state_e          state,
   input  logic [ROW_BITS-1:0] addr_row,
   input  logic [COL_BITS-1:0] addr_col,
   input  logic [DW-1:0]       dq_in,
   output logic [DW-1:0]       dq_out,
   output logic                dq_oe
);
   localparam int WAW   = ROW_BITS + COL_BITS;
   localparam int WORDS = 1 << WAW;

   logic [DW-1:0]       mem [WORDS];
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic                dvalid;
   logic                acc, wr_early, wr_late, wr_en;
   logic [WAW-1:0]      waddr;

   assign acc      = cas_fall && (state == ST_OPEN);
   assign wr_early = acc && !we_n;
   assign wr_late  = we_fall && !acc && !cas_n && !r_cas && (state == ST_OPEN);
   assign wr_en    = wr_early || wr_late;
   assign waddr    = acc ? {row_q, addr_col} : {row_q, col_q};

   always_ff @(posedge clk) begin
      if (wr_en) mem[waddr] <= dq_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         dq_out <= '0;
         dvalid <= 1'b0;
      end else begin
         if (ras_fall) row_q <= addr_row;
         if (acc)      col_q <= addr_col;
         if (acc && we_n) begin
            dq_out <= mem[{row_q, addr_col}];
            dvalid <= 1'b1;
         end else if (wr_early || (ras_n && cas_n)) begin
            dvalid <= 1'b0;
         end
      end
   end

   generate
      if (EDO_MODE) begin : g_edo
         assign dq_oe = dvalid && !r_oe && r_we;
      end else begin : g_fast_page
         assign dq_oe = dvalid && !r_oe && r_we && !r_cas;
      end
   endgenerate

   assert_hiz_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !(r_ras && r_cas));
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
   import edo_pkg::*;
#(
   parameter int ROW_BITS    = 4,
   parameter int COL_BITS    = 4,
   parameter int DW          = 4,
   parameter int T_RP        = 3,
   parameter int T_CP        = 1,
   parameter int SELF_ENTER  = 12500,
   parameter int SELF_PERIOD = 64,
   parameter bit EDO_MODE    = 1'b1,
   localparam int AW = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                oe_n,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       dq_in,
   output logic [DW-1:0]       dq_out,
   output logic                dq_oe,
   output logic                ref_stb,
   output logic [ROW_BITS-1:0] ref_row,
   output logic                self_ref,
   output logic                timing_err
);
   initial begin
      assert (ROW_BITS >= 1 && COL_BITS >= 1 && ROW_BITS + COL_BITS <= 12)
         else $error("array geometry out of range");
      assert (DW >= 1) else $error("data width must be positive");
      assert (T_RP >= 1 && T_CP >= 1) else $error("precharge minimums must be positive");
      assert (SELF_ENTER >= 2 && SELF_PERIOD >= 1) else $error("self-refresh timing out of range");
   end

   logic       r_ras, r_cas, r_we, r_oe;
   logic       ras_fall, cas_fall, we_fall;
   edo_state_e state;

   edo_strobe_sync u_sync (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .r_ras(r_ras), .r_cas(r_cas), .r_we(r_we), .r_oe(r_oe),
      .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
   );

   edo_cycle_fsm #(
      .ROW_BITS(ROW_BITS), .SELF_ENTER(SELF_ENTER), .SELF_PERIOD(SELF_PERIOD)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .r_ras(r_ras), .r_cas(r_cas),
      .ras_fall(ras_fall), .addr_row(addr[ROW_BITS-1:0]),
      .state(state), .ref_stb(ref_stb), .ref_row(ref_row), .self_ref(self_ref)
   );

   edo_timing_mon #(.T_RP(T_RP), .T_CP(T_CP)) u_tmon (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .r_ras(r_ras), .r_cas(r_cas),
      .ras_fall(ras_fall), .cas_fall(cas_fall), .state(state),
      .timing_err(timing_err)
   );

   edo_cell_array #(
      .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW), .EDO_MODE(EDO_MODE)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .r_ras(r_ras), .r_cas(r_cas), .r_we(r_we), .r_oe(r_oe),
      .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall),
      .state(state),
      .addr_row(addr[ROW_BITS-1:0]), .addr_col(addr[COL_BITS-1:0]),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );
endmodule

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;
   localparam int RB = 3, CB = 2, DW = 4, TRP = 3, TCP = 2, SE = 20, SP = 5;
   localparam int AW = 3, ROWS = 8, COLS = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, ras_n, cas_n, we_n, oe_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic dq_oe, ref_stb, self_ref, timing_err;
   logic [RB-1:0] ref_row;

   int checks = 0, errors = 0, exp_ref = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [ROWS*COLS];

   edo_dram_model #(
      .ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .T_RP(TRP), .T_CP(TCP),
      .SELF_ENTER(SE), .SELF_PERIOD(SP), .EDO_MODE(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .ref_stb(ref_stb), .ref_row(ref_row), .self_ref(self_ref),
      .timing_err(timing_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic precharge();
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (TRP) tick();
   endtask

   task automatic write_word(input int r, input int c, input logic [DW-1:0] d);
      addr = AW'(r); ras_n = 1'b0; tick();
      chk(ref_stb == 1'b1 && int'(ref_row) == r, "R2 row-open refresh strobe", int'(ref_row), r);
      chk(timing_err == 1'b0, "R9 no error on legal precharge", int'(timing_err), 0);
      addr = AW'(c); dq_in = d; we_n = 1'b0; cas_n = 1'b0; tick();
      chk(dq_oe == 1'b0, "R5 no drive during write", int'(dq_oe), 0);
      cas_n = 1'b1; we_n = 1'b1; tick();
      precharge();
      model[r*COLS+c] = d;
   endtask

   task automatic read_word(input int r, input int c);
      int e;
      e = int'(model[r*COLS+c]);
      addr = AW'(r); oe_n = 1'b0; ras_n = 1'b0; tick();
      chk(dq_oe == 1'b0, "R2 no drive before column", int'(dq_oe), 0);
      addr = AW'(c); cas_n = 1'b0; tick();
      chk(dq_oe == 1'b1, "R4 drive after read", int'(dq_oe), 1);
      chk(int'(dq_out) == e, "R3 R4 read data", int'(dq_out), e);
      cas_n = 1'b1; tick();
      chk(dq_oe == 1'b1 && int'(dq_out) == e, "R4 extended hold in precharge", int'(dq_out), e);
      ras_n = 1'b1; tick();
      chk(dq_oe == 1'b0, "R5 release on both high", int'(dq_oe), 0);
      precharge();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = '0; dq_in = '0;
      repeat (3) tick();
      rst_n = 1'b1; tick();
      // R1 reset state
      chk(dq_oe == 1'b0, "R1 dq_oe reset", int'(dq_oe), 0);
      chk(ref_stb == 1'b0, "R1 ref_stb reset", int'(ref_stb), 0);
      chk(self_ref == 1'b0, "R1 self_ref reset", int'(self_ref), 0);
      chk(timing_err == 1'b0, "R1 timing_err reset", int'(timing_err), 0);

      // R3 / R4 exhaustive sweep: early writes then reads of every word
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            write_word(r, c, DW'((r*5 + c*3 + 1) % 16));
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            read_word(r, c);

      // R3 late write: read first, then WE falls while CAS is low
      addr = 3'd2; oe_n = 1'b0; ras_n = 1'b0; tick();
      addr = 3'd1; cas_n = 1'b0; tick();
      chk(int'(dq_out) == int'(model[2*COLS+1]), "R4 read before late write", int'(dq_out), int'(model[2*COLS+1]));
      dq_in = 4'hA; we_n = 1'b0; tick();
      chk(dq_oe == 1'b0, "R5 WE low releases output", int'(dq_oe), 0);
      model[2*COLS+1] = 4'hA;
      we_n = 1'b1; tick();
      precharge();
      read_word(2, 1);

      // R3 WE falls first, data taken at the later CAS fall
      addr = 3'd4; ras_n = 1'b0; tick();
      we_n = 1'b0; dq_in = 4'h3; tick();
      dq_in = 4'hC; addr = 3'd2; cas_n = 1'b0; tick();
      model[4*COLS+2] = 4'hC;
      cas_n = 1'b1; we_n = 1'b1; tick();
      precharge();
      read_word(4, 2);

      // R4 page mode with extended output, R5 OE control
      addr = 3'd5; oe_n = 1'b0; ras_n = 1'b0; tick();
      for (int c = 0; c < COLS; c++) begin
         addr = AW'(c); cas_n = 1'b0; tick();
         chk(int'(dq_out) == int'(model[5*COLS+c]), "R4 page read data", int'(dq_out), int'(model[5*COLS+c]));
         chk(timing_err == 1'b0, "R9 legal column precharge", int'(timing_err), 0);
         cas_n = 1'b1; tick();
         chk(dq_oe == 1'b1 && int'(dq_out) == int'(model[5*COLS+c]), "R4 page hold", int'(dq_out), int'(model[5*COLS+c]));
         tick();
      end
      oe_n = 1'b1; tick();
      chk(dq_oe == 1'b0, "R5 OE high releases", int'(dq_oe), 0);
      oe_n = 1'b0; tick();
      chk(dq_oe == 1'b1, "R4 OE low drives again", int'(dq_oe), 1);
      precharge();

      // R9 short column precharge inside an open row
      addr = 3'd5; oe_n = 1'b0; ras_n = 1'b0; tick();
      addr = 3'd0; cas_n = 1'b0; tick();
      cas_n = 1'b1; tick();
      addr = 3'd2; cas_n = 1'b0; tick();
      chk(timing_err == 1'b1, "R9 short CAS precharge flagged", int'(timing_err), 1);
      chk(int'(dq_out) == int'(model[5*COLS+2]), "R4 read despite error", int'(dq_out), int'(model[5*COLS+2]));
      tick();
      chk(timing_err == 1'b0, "R9 error is one cycle", int'(timing_err), 0);
      precharge();

      // R2 RAS-only refresh and R9 short RAS precharge
      addr = 3'd6; oe_n = 1'b0; ras_n = 1'b0; tick();
      chk(ref_stb == 1'b1 && ref_row == 3'd6, "R2 RAS-only refresh row", int'(ref_row), 6);
      ras_n = 1'b1; tick();
      addr = 3'd1; ras_n = 1'b0; tick();
      chk(timing_err == 1'b1, "R9 short RAS precharge flagged", int'(timing_err), 1);
      chk(ref_stb == 1'b1 && ref_row == 3'd1, "R2 refresh of addressed row", int'(ref_row), 1);
      chk(dq_oe == 1'b0, "R2 outputs undriven without CAS", int'(dq_oe), 0);
      tick();
      chk(timing_err == 1'b0 && ref_stb == 1'b0, "R9 R2 single-cycle pulses", int'(ref_stb), 0);
      precharge();

      // R6 CBR refresh: counter order, wrap, address/WE ignored
      for (int i = 0; i < ROWS + 2; i++) begin
         addr = AW'(i); dq_in = 4'hF; we_n = 1'b0; oe_n = 1'b0;
         cas_n = 1'b0; tick();
         ras_n = 1'b0; tick();
         chk(ref_stb == 1'b1 && int'(ref_row) == exp_ref, "R6 CBR counter row", int'(ref_row), exp_ref);
         chk(dq_oe == 1'b0, "R6 CBR leaves outputs off", int'(dq_oe), 0);
         exp_ref = (exp_ref + 1) % ROWS;
         tick();
         chk(ref_stb == 1'b0, "R6 one refresh per CBR", int'(ref_stb), 0);
         ras_n = 1'b1; tick();
         precharge();
      end
      read_word(3, 2);
      read_word(0, 0);

      // R8 hidden refresh keeps read data driven
      addr = 3'd6; oe_n = 1'b0; ras_n = 1'b0; tick();
      addr = 3'd1; cas_n = 1'b0; tick();
      chk(int'(dq_out) == int'(model[6*COLS+1]), "R8 read before hidden refresh", int'(dq_out), int'(model[6*COLS+1]));
      ras_n = 1'b1; repeat (TRP) tick();
      chk(dq_oe == 1'b1 && int'(dq_out) == int'(model[6*COLS+1]), "R8 held during RAS high", int'(dq_out), int'(model[6*COLS+1]));
      ras_n = 1'b0; tick();
      chk(ref_stb == 1'b1 && int'(ref_row) == exp_ref, "R8 hidden refresh uses counter", int'(ref_row), exp_ref);
      exp_ref = (exp_ref + 1) % ROWS;
      chk(dq_oe == 1'b1 && int'(dq_out) == int'(model[6*COLS+1]), "R8 held after second RAS fall", int'(dq_out), int'(model[6*COLS+1]));
      ras_n = 1'b1; cas_n = 1'b1; tick();
      chk(dq_oe == 1'b0, "R5 release after hidden refresh", int'(dq_oe), 0);
      precharge();

      // R7 self-refresh entry, periodic refresh with CAS released, exit
      cas_n = 1'b0; tick();
      ras_n = 1'b0; tick();
      chk(ref_stb == 1'b1 && int'(ref_row) == exp_ref, "R7 entry CBR row", int'(ref_row), exp_ref);
      exp_ref = (exp_ref + 1) % ROWS;
      repeat (SE - 1) tick();
      chk(self_ref == 1'b0, "R7 not yet in self-refresh", int'(self_ref), 0);
      tick();
      chk(self_ref == 1'b1, "R7 self-refresh entered", int'(self_ref), 1);
      for (int i = 1; i <= 3*SP; i++) begin
         if (i == 3) cas_n = 1'b1;
         tick();
         if (i % SP == 0) begin
            chk(ref_stb == 1'b1 && int'(ref_row) == exp_ref, "R7 periodic self-refresh row", int'(ref_row), exp_ref);
            exp_ref = (exp_ref + 1) % ROWS;
         end else begin
            chk(ref_stb == 1'b0, "R7 no refresh between periods", int'(ref_stb), 0);
         end
         chk(self_ref == 1'b1, "R7 stays in self-refresh", int'(self_ref), 1);
      end
      ras_n = 1'b1; tick();
      chk(self_ref == 1'b0, "R7 exit on RAS high", int'(self_ref), 0);
      precharge();
      cas_n = 1'b0; tick();
      ras_n = 1'b0; tick();
      chk(ref_stb == 1'b1 && int'(ref_row) == exp_ref, "R6 counter continues after self-refresh", int'(ref_row), exp_ref);
      ras_n = 1'b1; tick();
      precharge();

      finish_run();
   end
endmodule